// File: doc/BRIEF.md
# Virtual-to-Physical Address Translator with Buffered Page-Table Walk

The block converts a 14-bit byte virtual address into a 10-bit physical address. The low 8 bits are the offset inside a 256-byte page and pass through unchanged. The upper 6 bits are the virtual page number, and they are replaced by a 2-bit frame number. A four-entry, fully associative translation buffer is searched first, with all tags compared in parallel. On a miss, the unit reads a 64-entry page table held in local registers. If the mapping is valid, the buffer is refilled using least-recently-used replacement. If it is not valid, the unit only flags a page fault.

Write requests mark the matching buffer entry as modified. That modified state reaches the page table only when the entry is evicted, so the buffer is write-back toward the table. A side port lets a host install mappings in the table and read any table entry back. Requests use a valid/ready handshake. Each accepted request produces one single-cycle response pulse.

Top module: `xlat_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, every table entry is invalid and the buffer holds no translations, so the first access to any page is a miss.
- R2: A successful translation returns `rsp_paddr` = {frame[1:0], vaddr[7:0]} with `rsp_fault` = 0.
- R3: A buffer hit is answered one cycle after acceptance with `rsp_hit` = 1. It uses the frame stored at fill time, so a later table change does not affect it.
- R4: A miss is answered two cycles after acceptance with `rsp_hit` = 0, and `req_ready` is 0 during the walk cycle.
- R5: A miss on an invalid table entry answers with `rsp_fault` = 1 and `rsp_paddr` = 0 and installs nothing in the buffer, so the next access to that page misses again.
- R6: A fill replaces the least recently used entry, and invalid entries are used before any valid one is evicted. A hit or a fill makes that entry the most recently used.
- R7: A write request marks the hit or filled entry as modified. The table's dirty flag for that page becomes 1 only when the modified entry is evicted.
- R8: Evicting an unmodified entry leaves the table's dirty flag unchanged.
- R9: Each accepted request yields exactly one `rsp_valid` pulse, one cycle long, and `req_ready` is 1 again once the response is given.
- R10: The four buffer recency ranks always form a permutation of 0..3.
- R11: A load on the table port writes the valid flag and frame for a page and clears its dirty flag. The inspect port shows an entry's valid flag, frame and dirty flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | 14 | Virtual byte address |
| req_write | input | 1 | Request is a store |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 10 | Physical address, 0 on fault |
| rsp_fault | output | 1 | Page fault indication |
| rsp_hit | output | 1 | Response came from the buffer |
| pt_ld_en | input | 1 | Table load strobe |
| pt_ld_vpn | input | 6 | Page number to load |
| pt_ld_valid | input | 1 | Valid flag to load |
| pt_ld_pfn | input | 2 | Frame number to load |
| pt_rd_vpn | input | 6 | Page number to inspect |
| pt_rd_valid | output | 1 | Inspected valid flag |
| pt_rd_pfn | output | 2 | Inspected frame number |
| pt_rd_dirty | output | 1 | Inspected dirty flag |

## Verification
A hit answers on the first clock edge after acceptance. A miss or fault answers on the second edge, and `req_ready` is low in between. The bench drives each request on a falling edge and then counts falling edges until `rsp_valid` appears, and compares that count with the latency its own recency model predicts. Response fields and the inspect port are sampled on falling edges, well away from the register updates, and `rsp_valid` is checked to fall on the edge after each pulse. Every table page is swept in turn with mixed reads and writes, which forces many evictions. The dirty flags of all 64 pages are then compared with the model.

// File: rtl/xlat_pkg.sv
// Shared geometry and entry types for the address translator.
// Assumes the page offset width is smaller than both address widths.
package xlat_pkg;
    localparam int VA_W   = 14;
    localparam int PA_W   = 10;
    localparam int OFF_W  = 8;
    localparam int TLB_N  = 4;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PFN_W  = PA_W - OFF_W;
    localparam int PT_N   = 1 << VPN_W;
    localparam int IDX_W  = $clog2(TLB_N);
    localparam int RANK_W = IDX_W;

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic [VPN_W-1:0] tag;
        logic [PFN_W-1:0] pfn;
    } tlb_entry_t;

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic [PFN_W-1:0] pfn;
    } pte_t;
endpackage

// File: rtl/xlat_page_table.sv
// Register-array page table, one entry per virtual page.
// Host loads have priority over eviction write-backs in the same cycle.
// Assumes the host does not invalidate a page while it is held in the buffer.
module xlat_page_table
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [VPN_W-1:0] ld_vpn,
    input  logic             ld_valid,
    input  logic [PFN_W-1:0] ld_pfn,
    input  logic             wb_en,
    input  logic [VPN_W-1:0] wb_vpn,
    input  logic [VPN_W-1:0] walk_vpn,
    output logic             walk_valid,
    output logic [PFN_W-1:0] walk_pfn,
    input  logic [VPN_W-1:0] rd_vpn,
    output logic             rd_valid,
    output logic [PFN_W-1:0] rd_pfn,
    output logic             rd_dirty
);
    pte_t tab [PT_N];

    // Table update: clear on reset, host load, or dirty write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PT_N; i++) tab[i] <= '0;
        end else if (ld_en) begin
            tab[ld_vpn] <= '{valid: ld_valid, dirty: 1'b0, pfn: ld_pfn};
        end else if (wb_en) begin
            tab[wb_vpn].dirty <= 1'b1;
        end
    end

    // Combinational read ports for the walker and the inspector.
    always_comb begin
        walk_valid = tab[walk_vpn].valid;
        walk_pfn   = tab[walk_vpn].pfn;
        rd_valid   = tab[rd_vpn].valid;
        rd_pfn     = tab[rd_vpn].pfn;
        rd_dirty   = tab[rd_vpn].dirty;
    end

    // R7: a write-back only ever targets a page that is mapped.
    a_r7_wb_mapped_page: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !ld_en) |-> tab[wb_vpn].valid);
endmodule

// File: rtl/xlat_tlb.sv
// Fully associative translation buffer with recency ranks.
// Rank 0 = most recent, TLB_N-1 = least recent, which is the victim.
// Assumes touch_en and fill_en are never both high in one cycle.
module xlat_tlb
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             hit,
    output logic [PFN_W-1:0] hit_pfn,
    output logic             vict_valid,
    output logic             vict_dirty,
    output logic [VPN_W-1:0] vict_tag,
    input  logic             touch_en,
    input  logic             touch_wr,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_tag,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_dirty
);
    tlb_entry_t        ent  [TLB_N];
    logic [RANK_W-1:0] rank [TLB_N];
    logic [TLB_N-1:0]  match;
    logic [TLB_N-1:0]  vld_vec;
    logic [TLB_N-1:0]  vict_oh;
    logic [TLB_N-1:0]  rank_seen;
    logic [IDX_W-1:0]  hit_idx;
    logic [IDX_W-1:0]  vict_idx;
    logic [IDX_W-1:0]  use_idx;

    // Parallel tag comparators, one per entry.
    for (genvar g = 0; g < TLB_N; g++) begin : g_cmp
        assign match[g]   = ent[g].valid && (ent[g].tag == look_vpn);
        assign vld_vec[g] = ent[g].valid;
        assign vict_oh[g] = (rank[g] == RANK_W'(TLB_N - 1));
    end

    // Encode the hit index and the victim index.
    always_comb begin
        hit_idx  = '0;
        vict_idx = '0;
        for (int i = 0; i < TLB_N; i++) begin
            if (match[i])   hit_idx  = IDX_W'(i);
            if (vict_oh[i]) vict_idx = IDX_W'(i);
        end
        hit        = |match;
        hit_pfn    = ent[hit_idx].pfn;
        vict_valid = ent[vict_idx].valid;
        vict_dirty = ent[vict_idx].dirty;
        vict_tag   = ent[vict_idx].tag;
        use_idx    = fill_en ? vict_idx : hit_idx;
    end

    // Rank occupancy, used by the permutation check.
    always_comb begin
        rank_seen = '0;
        for (int i = 0; i < TLB_N; i++) rank_seen[rank[i]] = 1'b1;
    end

    // Entry contents: fill the victim or mark the hit entry as written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TLB_N; i++) ent[i] <= '0;
        end else if (fill_en) begin
            ent[vict_idx] <= '{valid: 1'b1, dirty: fill_dirty, tag: fill_tag, pfn: fill_pfn};
        end else if (touch_en && touch_wr) begin
            ent[hit_idx].dirty <= 1'b1;
        end
    end

    // Recency update: the used entry moves to rank 0, more recent ones age by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TLB_N; i++) rank[i] <= RANK_W'(i);
        end else if (fill_en || touch_en) begin
            for (int i = 0; i < TLB_N; i++) begin
                if (IDX_W'(i) == use_idx)         rank[i] <= '0;
                else if (rank[i] < rank[use_idx]) rank[i] <= rank[i] + 1'b1;
            end
        end
    end

    // R10: ranks stay a permutation.
    a_r10_rank_perm: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rank_seen) == TLB_N);
    // R3: at most one entry matches a page number.
    a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
    // R6: the filled slot is valid afterwards.
    a_r6_fill_installs: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> ((vld_vec & $past(vict_oh)) != '0));
    // R6: invalid slots are consumed before a valid one is evicted.
    a_r6_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && vict_valid) |-> (&vld_vec));
endmodule

// File: rtl/xlat_unit.sv
// Translation unit top: buffer lookup, one-cycle table walk, fault flag.
// Hits answer one cycle after acceptance, misses and faults after two.
// Assumes the host table port is not used while requests are in flight.
module xlat_unit
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_fault,
    output logic             rsp_hit,
    input  logic             pt_ld_en,
    input  logic [VPN_W-1:0] pt_ld_vpn,
    input  logic             pt_ld_valid,
    input  logic [PFN_W-1:0] pt_ld_pfn,
    input  logic [VPN_W-1:0] pt_rd_vpn,
    output logic             pt_rd_valid,
    output logic [PFN_W-1:0] pt_rd_pfn,
    output logic             pt_rd_dirty
);
    typedef enum logic {ST_IDLE, ST_WALK} state_t;

    state_t           state;
    logic [VPN_W-1:0] lat_vpn;
    logic [OFF_W-1:0] lat_off;
    logic             lat_wr;
    logic             accept;
    logic             tlb_hit;
    logic [PFN_W-1:0] tlb_pfn;
    logic             v_valid, v_dirty;
    logic [VPN_W-1:0] v_tag;
    logic             touch_en, fill_en, wb_en;
    logic             walk_valid;
    logic [PFN_W-1:0] walk_pfn;

    // Handshake and buffer control decode.
    always_comb begin
        req_ready = (state == ST_IDLE);
        accept    = req_valid && req_ready;
        touch_en  = accept && tlb_hit;
        fill_en   = (state == ST_WALK) && walk_valid;
        wb_en     = fill_en && v_valid && v_dirty;
    end

    xlat_tlb u_tlb (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_vpn   (req_vaddr[VA_W-1:OFF_W]),
        .hit        (tlb_hit),
        .hit_pfn    (tlb_pfn),
        .vict_valid (v_valid),
        .vict_dirty (v_dirty),
        .vict_tag   (v_tag),
        .touch_en   (touch_en),
        .touch_wr   (req_write),
        .fill_en    (fill_en),
        .fill_tag   (lat_vpn),
        .fill_pfn   (walk_pfn),
        .fill_dirty (lat_wr)
    );

    xlat_page_table u_pt (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_en      (pt_ld_en),
        .ld_vpn     (pt_ld_vpn),
        .ld_valid   (pt_ld_valid),
        .ld_pfn     (pt_ld_pfn),
        .wb_en      (wb_en),
        .wb_vpn     (v_tag),
        .walk_vpn   (lat_vpn),
        .walk_valid (walk_valid),
        .walk_pfn   (walk_pfn),
        .rd_vpn     (pt_rd_vpn),
        .rd_valid   (pt_rd_valid),
        .rd_pfn     (pt_rd_pfn),
        .rd_dirty   (pt_rd_dirty)
    );

    // Control state, request latch and registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            lat_vpn   <= '0;
            lat_off   <= '0;
            lat_wr    <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= 1'b0;
            rsp_hit   <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: if (accept) begin
                    lat_vpn <= req_vaddr[VA_W-1:OFF_W];
                    lat_off <= req_vaddr[OFF_W-1:0];
                    lat_wr  <= req_write;
                    if (tlb_hit) begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= 1'b1;
                        rsp_fault <= 1'b0;
                        rsp_paddr <= {tlb_pfn, req_vaddr[OFF_W-1:0]};
                    end else begin
                        state <= ST_WALK;
                    end
                end
                ST_WALK: begin
                    rsp_valid <= 1'b1;
                    rsp_hit   <= 1'b0;
                    rsp_fault <= !walk_valid;
                    rsp_paddr <= walk_valid ? {walk_pfn, lat_off} : '0;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9: responses are single-cycle pulses.
    a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R3: a hit is answered on the next cycle.
    a_r3_hit_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && tlb_hit) |=> (rsp_valid && rsp_hit));
    // R4: a miss blocks for one walk cycle, then answers.
    a_r4_miss_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !tlb_hit) |=> (!rsp_valid && !req_ready) ##1 (rsp_valid && !rsp_hit));
    // R5: a fault never carries an address.
    a_r5_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_paddr == '0));
endmodule

// File: tb/xlat_unit_tb.sv
// Self-checking bench with a behavioural recency-list model of the buffer.
module xlat_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [13:0] req_vaddr = '0;
    logic        req_ready, rsp_valid, rsp_fault, rsp_hit;
    logic [9:0]  rsp_paddr;
    logic        pt_ld_en = 1'b0, pt_ld_valid = 1'b0;
    logic [5:0]  pt_ld_vpn = '0, pt_rd_vpn = '0;
    logic [1:0]  pt_ld_pfn = '0;
    logic        pt_rd_valid, pt_rd_dirty;
    logic [1:0]  pt_rd_pfn;

    int checks = 0;
    int fails  = 0;

    // Model: page table plus a recency-ordered list (index 0 = most recent).
    bit         mv [64];
    logic [1:0] mp [64];
    bit         md [64];
    int         tcnt = 0;
    logic [5:0] ttag [4];
    logic [1:0] tpfn [4];
    bit         tdirty [4];

    always #4 clk = ~clk;

    xlat_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_hit(rsp_hit),
        .pt_ld_en(pt_ld_en), .pt_ld_vpn(pt_ld_vpn),
        .pt_ld_valid(pt_ld_valid), .pt_ld_pfn(pt_ld_pfn),
        .pt_rd_vpn(pt_rd_vpn), .pt_rd_valid(pt_rd_valid),
        .pt_rd_pfn(pt_rd_pfn), .pt_rd_dirty(pt_rd_dirty)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pt_load(input int vpn, input bit v, input logic [1:0] pfn);
        @(negedge clk);
        pt_ld_en = 1'b1; pt_ld_vpn = 6'(vpn); pt_ld_valid = v; pt_ld_pfn = pfn;
        @(negedge clk);
        pt_ld_en = 1'b0;
        mv[vpn] = v; mp[vpn] = pfn; md[vpn] = 1'b0;
    endtask

    task automatic pt_inspect(input int vpn, input string req);
        @(negedge clk);
        pt_rd_vpn = 6'(vpn);
        #1;
        chk(pt_rd_valid == mv[vpn] && pt_rd_pfn == mp[vpn] && pt_rd_dirty == md[vpn],
            req, $sformatf("table entry %0d {v,pfn,d}", vpn),
            {pt_rd_valid, pt_rd_pfn, pt_rd_dirty}, {mv[vpn], mp[vpn], md[vpn]});
    endtask

    // Issue one request; predict its outcome from the model and compare.
    task automatic access(input int vpn, input int off, input bit wr, input string req);
        int         pos = -1;
        int         lat;
        bit         e_hit, e_fault, ready_low;
        logic [9:0] e_pa;
        for (int i = 0; i < tcnt; i++) if (ttag[i] == 6'(vpn)) pos = i;
        if (pos >= 0) begin
            logic [5:0] t = ttag[pos];
            logic [1:0] p = tpfn[pos];
            bit         d = tdirty[pos] | wr;
            e_hit = 1; e_fault = 0; e_pa = {p, 8'(off)};
            for (int i = pos; i > 0; i--) begin
                ttag[i] = ttag[i-1]; tpfn[i] = tpfn[i-1]; tdirty[i] = tdirty[i-1];
            end
            ttag[0] = t; tpfn[0] = p; tdirty[0] = d;
        end else if (mv[vpn]) begin
            e_hit = 0; e_fault = 0; e_pa = {mp[vpn], 8'(off)};
            if (tcnt == 4) begin
                if (tdirty[3]) md[ttag[3]] = 1'b1;
            end else tcnt++;
            for (int i = tcnt - 1; i > 0; i--) begin
                ttag[i] = ttag[i-1]; tpfn[i] = tpfn[i-1]; tdirty[i] = tdirty[i-1];
            end
            ttag[0] = 6'(vpn); tpfn[0] = mp[vpn]; tdirty[0] = wr;
        end else begin
            e_hit = 0; e_fault = 1; e_pa = '0;
        end

        @(negedge clk);
        req_valid = 1'b1; req_vaddr = {6'(vpn), 8'(off)}; req_write = wr;
        chk(req_ready == 1'b1, "R9", "ready before request", req_ready, 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        ready_low = 1'b0;
        while (!rsp_valid && lat < 8) begin
            if (lat == 1) ready_low = !req_ready;
            @(negedge clk);
            lat++;
        end
        chk(lat == (e_hit ? 1 : 2), e_hit ? "R3" : "R4", "response latency", lat, e_hit ? 1 : 2);
        if (!e_hit) chk(ready_low, "R4", "ready low in walk", !ready_low, 0);
        chk(rsp_hit == e_hit, "R6", $sformatf("hit flag page %0d", vpn), rsp_hit, e_hit);
        chk(rsp_fault == e_fault, "R5", "fault flag", rsp_fault, e_fault);
        chk(rsp_paddr == e_pa, req, $sformatf("paddr page %0d", vpn), rsp_paddr, e_pa);
        @(negedge clk);
        chk(!rsp_valid, "R9", "response pulse width", rsp_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin mv[i] = 0; mp[i] = '0; md[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of the handshake and the table.
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1", "no response after reset", rsp_valid, 0);
        pt_inspect(9, "R1");

        // R11: install every page, every fifth invalid, and read back.
        for (int v = 0; v < 64; v++) pt_load(v, (v % 5) != 4, 2'((v * 3) % 4));
        for (int v = 0; v < 64; v++) pt_inspect(v, "R11");

        // R2 sweep: miss then hit on each page, writes on every third page.
        for (int v = 0; v < 64; v++) begin
            access(v, (v * 7 + 1) % 256, (v % 3) == 0, "R2");
            access(v, (v * 13 + 200) % 256, 1'b0, "R2");
        end
        // R7 R8: dirty flags after the many evictions of the sweep.
        for (int v = 0; v < 64; v++) pt_inspect(v, (v % 3) == 0 ? "R7" : "R8");

        // R6: recency order decides the victim.
        access(1, 5, 0, "R6"); access(2, 6, 0, "R6");
        access(3, 7, 0, "R6"); access(5, 8, 0, "R6");
        access(1, 9, 0, "R6"); access(6, 10, 0, "R6");
        access(2, 11, 0, "R6"); access(3, 12, 0, "R6");
        access(1, 13, 0, "R6");

        // R7: a write stays in the buffer until the entry is evicted.
        access(7, 33, 1, "R7");
        pt_inspect(7, "R7");
        access(8, 1, 0, "R7"); access(10, 2, 0, "R7");
        access(11, 3, 0, "R7"); access(12, 4, 0, "R7");
        pt_inspect(7, "R7");

        // R5: a fault installs nothing; after mapping, the page misses then hits.
        access(4, 77, 0, "R5");
        access(4, 78, 1, "R5");
        pt_load(4, 1'b1, 2'd2);
        access(4, 79, 0, "R5");
        access(4, 80, 0, "R5");

        // R3: a remap in the table does not affect a buffered translation.
        pt_load(4, 1'b1, 2'd1);
        access(4, 81, 0, "R3");
        pt_inspect(4, "R11");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule